// File: doc/BRIEF.md
# Local Priority Transmit Selector

This block picks the next transmit message buffer to load for sending. Every buffer presents a 4-bit control code, an IDE bit, a 29-bit ID field and a 3-bit local priority field. When a select request arrives, the block scans all buffers and considers only those marked ready to transmit. It reports the index of the buffer with the lowest arbitration key, or that no buffer is ready.

The arbitration key places the local priority field in front of the CAN identifier, so software can rank outgoing frames on top of their bus IDs. A global enable input controls whether the priority field takes part in the comparison. The priority bits are never part of the identifier reported for sending. Frame serialisation and on-wire arbitration belong to other blocks.

Top module: `tx_prio_select`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `sel_done`, `sel_found`, `sel_idx`, `win_id` and `win_ide` are all zero.
- R2: A request sampled high at a rising clock edge updates the result at that same edge, and `sel_done` is high for the cycle that follows. `sel_done` is low after any edge that sampled no request. Between completions, the result outputs hold their values.
- R3: Only a buffer whose code is 4'b1100 is eligible. Any other code, including 4'b1000 (inactive transmit), is never selected. If no buffer is eligible, `sel_found` is 0 and `sel_idx` is 0.
- R4: The key has 33 bits. From most to least significant it holds: priority (3 bits), base ID (11 bits), IDE (1 bit) and extension (18 bits). Among eligible buffers, the lowest key wins.
- R5: A standard frame (IDE=0) takes its base ID from `id[10:0]` and uses an extension of zero. An extended frame (IDE=1) takes its base ID from `id[28:18]` and its extension from `id[17:0]`. As a result, a standard frame beats an extended frame that has the same base ID.
- R6: When `lprio_en` is 0, the priority part of every key is taken as 0, so the priority fields have no effect on the choice.
- R7: When two eligible keys are equal, the buffer with the lower index wins.
- R8: `win_ide` equals the IDE bit of the winner. `win_id` carries the winner's transmitted ID without any priority bits. For a standard frame this is `id[10:0]` in bits [10:0] with zeros above. For an extended frame it is `id[28:0]`. Both outputs are 0 when nothing is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lprio_en | input | 1 | Local priority takes part in the key |
| sel_req | input | 1 | Select request |
| buf_code | input | NBUF*4 | Control code per buffer, buffer i at [4i+3:4i] |
| buf_ide | input | NBUF | IDE bit per buffer |
| buf_id | input | NBUF*29 | ID field per buffer, buffer i at [29i+28:29i] |
| buf_prio | input | NBUF*3 | Local priority per buffer, buffer i at [3i+2:3i] |
| sel_done | output | 1 | Result completed in the previous edge |
| sel_found | output | 1 | An eligible buffer was found |
| sel_idx | output | IDXW | Winning buffer index |
| win_id | output | 29 | Transmitted ID of the winner |
| win_ide | output | 1 | IDE bit of the winner |

## Verification
Three rules can decide the same comparison in one request: priority ranking, the standard-over-extended ordering at an equal base ID, and the lower-index tie break. The bench provokes these collisions by drawing IDs from a tiny range, so base IDs and whole keys often coincide. It also toggles the priority enable between requests, and a bench model judges each result by computing the keys arithmetically. Directed cases set priority against ID, and a standard frame against an extended frame, in both enable states.

// File: rtl/tx_prio_select.sv
module tx_prio_select #(
  parameter int NBUF = 16,
  parameter int IDXW = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lprio_en,
  input  logic              sel_req,
  input  logic [NBUF*4-1:0] buf_code,
  input  logic [NBUF-1:0]   buf_ide,
  input  logic [NBUF*29-1:0] buf_id,
  input  logic [NBUF*3-1:0] buf_prio,
  output logic              sel_done,
  output logic              sel_found,
  output logic [IDXW-1:0]   sel_idx,
  output logic [28:0]       win_id,
  output logic              win_ide
);
  localparam int KEYW = 33;
  localparam logic [3:0] CODE_TX = 4'b1100;

  function automatic logic [KEYW-1:0] make_key(input logic en, input logic [2:0] pr,
                                               input logic ide, input logic [28:0] id);
    logic [10:0] base;
    logic [17:0] ext;
    base = ide ? id[28:18] : id[10:0];
    ext  = ide ? id[17:0] : 18'd0;
    return {(en ? pr : 3'd0), base, ide, ext};
  endfunction

  logic            best_ok;
  logic [KEYW-1:0] best_key;
  logic [IDXW-1:0] best_i;

  always_comb begin
    best_ok  = 1'b0;
    best_key = '1;
    best_i   = '0;
    for (int i = 0; i < NBUF; i++) begin
      logic [KEYW-1:0] k;
      k = make_key(lprio_en, buf_prio[i*3 +: 3], buf_ide[i], buf_id[i*29 +: 29]);
      if (buf_code[i*4 +: 4] == CODE_TX && (!best_ok || k < best_key)) begin
        best_ok  = 1'b1;
        best_key = k;
        best_i   = IDXW'(i);
      end
    end
  end

  logic [28:0] best_id;
  logic        best_ide;
  assign best_ide = best_ok & buf_ide[best_i];
  assign best_id  = !best_ok ? 29'd0 :
                    best_ide ? buf_id[best_i*29 +: 29] :
                               {18'd0, buf_id[best_i*29 +: 11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_done  <= 1'b0;
      sel_found <= 1'b0;
      sel_idx   <= '0;
      win_id    <= '0;
      win_ide   <= 1'b0;
    end else begin
      sel_done <= sel_req;
      if (sel_req) begin
        sel_found <= best_ok;
        sel_idx   <= best_i;
        win_id    <= best_id;
        win_ide   <= best_ide;
      end
    end
  end
endmodule

module tx_prio_select_chk #(
  parameter int NBUF = 16,
  parameter int IDXW = $clog2(NBUF)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_req,
  input logic [NBUF*4-1:0] buf_code,
  input logic              sel_done,
  input logic              sel_found,
  input logic [IDXW-1:0]   sel_idx,
  input logic [28:0]       win_id,
  input logic              win_ide
);
  logic [NBUF*4-1:0] cap_code;
  logic              cap_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_code <= '0;
    else if (sel_req) cap_code <= buf_code;
  end

  always_comb begin
    cap_any = 1'b0;
    for (int i = 0; i < NBUF; i++)
      if (cap_code[i*4 +: 4] == 4'b1100) cap_any = 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !sel_done); // R1
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) sel_req |=> sel_done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !sel_req |=> !sel_done); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_done |-> ($stable(sel_idx) && $stable(sel_found) && $stable(win_id))); // R2
  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && sel_found) |-> cap_code[sel_idx*4 +: 4] == 4'b1100); // R3
  AST_FOUND_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> sel_found == cap_any); // R3
  AST_STD_ID_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && !win_ide) |-> win_id[28:11] == 18'd0); // R8
endmodule

bind tx_prio_select tx_prio_select_chk #(.NBUF(NBUF), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .buf_code(buf_code),
  .sel_done(sel_done), .sel_found(sel_found), .sel_idx(sel_idx),
  .win_id(win_id), .win_ide(win_ide));

// File: tb/sim_tx_prio_select.sv
module sim_tx_prio_select;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0, lprio_en = 0, sel_req = 0;
  logic [NB*4-1:0] buf_code = '0;
  logic [NB-1:0] buf_ide = '0;
  logic [NB*29-1:0] buf_id = '0;
  logic [NB*3-1:0] buf_prio = '0;
  logic sel_done, sel_found, win_ide;
  logic [IW-1:0] sel_idx;
  logic [28:0] win_id;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_prio_select #(.NBUF(NB), .IDXW(IW)) u0 (.*);

  logic [3:0] c_a[NB];
  logic       e_a[NB];
  logic [28:0] i_a[NB];
  logic [2:0] p_a[NB];

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_key(int b, bit en);
    longint base, ext;
    base = e_a[b] ? longint'(i_a[b]) / 262144 : longint'(i_a[b]) % 2048;
    ext  = e_a[b] ? longint'(i_a[b]) % 262144 : 0;
    return (en ? longint'(p_a[b]) : 0) * 64'd1073741824 + base * 524288 + longint'(e_a[b]) * 262144 + ext;
  endfunction

  task automatic run_sel(input bit en, input string tag);
    int wi; bit f; longint bk; longint eid;
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      buf_code[b*4 +: 4] = c_a[b];
      buf_ide[b] = e_a[b];
      buf_id[b*29 +: 29] = i_a[b];
      buf_prio[b*3 +: 3] = p_a[b];
    end
    lprio_en = en;
    sel_req = 1;
    f = 0; wi = 0; bk = 0;
    for (int b = 0; b < NB; b++)
      if (c_a[b] == 4'hC && (!f || ref_key(b, en) < bk)) begin
        f = 1; wi = b; bk = ref_key(b, en);
      end
    eid = !f ? 0 : e_a[wi] ? longint'(i_a[wi]) : longint'(i_a[wi]) % 2048;
    @(negedge clk);
    sel_req = 0;
    chk("R2 done", sel_done, 1);
    chk({"R3 found ", tag}, sel_found, f);
    chk({"R4 idx ", tag}, sel_idx, wi);
    chk("R8 id", win_id, eid);
    chk("R8 ide", win_ide, f ? e_a[wi] : 0);
  endtask

  task automatic set_buf(int b, logic [3:0] c, logic e, logic [28:0] id, logic [2:0] p);
    c_a[b] = c; e_a[b] = e; i_a[b] = id; p_a[b] = p;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) set_buf(b, 4'h8, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 done", sel_done, 0);
    chk("R1 found", sel_found, 0);
    chk("R1 idx", sel_idx, 0);
    chk("R1 id", win_id, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", sel_done, 0);

    run_sel(1, "R3 all inactive");
    // R3: ineligible codes only; buffer 2 eligible with worst key
    set_buf(0, 4'h8, 0, 0, 0); set_buf(1, 4'h4, 0, 0, 0);
    set_buf(2, 4'hC, 1, 29'h1FFFFFFF, 7); set_buf(3, 4'hA, 0, 1, 0);
    run_sel(1, "R3 only one");
    @(negedge clk);
    chk("R2 done low", sel_done, 0);
    chk("R2 hold idx", sel_idx, 2);

    // R6: priority outranks ID only when enabled
    set_buf(0, 4'hC, 0, 29'd100, 5); set_buf(1, 4'hC, 0, 29'd700, 1);
    set_buf(2, 4'h8, 0, 0, 0); set_buf(3, 4'h8, 0, 0, 0);
    run_sel(1, "R6 en");
    chk("R6 en idx", sel_idx, 1);
    run_sel(0, "R6 dis");
    chk("R6 dis idx", sel_idx, 0);

    // R5: standard beats extended with same base
    set_buf(0, 4'hC, 1, {11'd50, 18'd0}, 0); set_buf(1, 4'hC, 0, 29'd50, 0);
    run_sel(1, "R5 std vs ext");
    chk("R5 idx", sel_idx, 1);
    chk("R8 std id", win_id, 50);

    // R7: equal keys, lower index wins
    set_buf(0, 4'h8, 0, 0, 0);
    set_buf(1, 4'hC, 0, 29'd9, 3); set_buf(2, 4'hC, 0, 29'd9, 3); set_buf(3, 4'hC, 0, {18'h3, 11'd9}, 3);
    run_sel(1, "R7 tie");
    chk("R7 idx", sel_idx, 1);

    // R4 sweep with tiny ID space to force collisions
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < NB; b++) begin
        int r; logic e;
        r = $urandom % 4;
        e = $urandom % 2;
        set_buf(b, r == 0 ? 4'h8 : (r == 1 ? 4'($urandom) : 4'hC), e,
                e ? {11'($urandom % 3), 16'd0, 2'($urandom)} : {18'($urandom), 11'($urandom % 3)},
                3'($urandom % 3));
      end
      run_sel(1'($urandom), "R4 sweep");
      if (n % 5 == 0) begin
        @(negedge clk);
        chk("R2 idle done", sel_done, 0);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule